// File: doc/BRIEF.md
# Decoding Integer Execute Unit

This block accepts a raw 32-bit instruction word together with the two register operand values that a register file has already read for it. It decodes the opcode and function fields itself, builds the second operand from either the register value or an extended 16-bit constant, and computes a 32-bit result. It also reports which register the result belongs in, whether the write should happen, and whether the instruction is outside the supported set.

The supported set is the register-format group (add, subtract, and, or, nor, set-less-than, shift left logical, shift right logical) and the immediate-format group (add immediate, set-less-than immediate, and immediate, or immediate, load upper immediate). Memory access, branches and jumps are not executed: they are flagged as illegal. The datapath is combinational. A parameter selects whether a single output register stage follows it.

With the default setting the outputs are registered. An instruction presented before a rising clock edge appears at the outputs after that edge.

Top module: `int_exec_unit`

## Requirements
- R1: Instruction fields are op = bits 31..26, first source = 25..21, second source/immediate destination = 20..16, register destination = 15..11, shift amount = 10..6, function = 5..0 and immediate constant = 15..0. With op 0, function 32 (add) and 34 (subtract) give operand_a plus/minus operand_b modulo 2^32. Op 8 (add immediate) adds the sign-extended constant to operand_a.
- R2: With op 0, function 36, 37 and 39 give the bitwise AND, OR and NOR of the two operands. Op 12 and op 13 AND/OR operand_a with the constant zero-extended to 32 bits.
- R3: With op 0, function 42 gives 1 when operand_a is less than operand_b as signed 32-bit numbers and 0 otherwise. Op 10 does the same against the sign-extended constant. No other result value is possible for these instructions.
- R4: With op 0, function 0 shifts operand_b left and function 2 shifts it right, both by the shift-amount field, with zeros filling the vacated bits. operand_a is not used.
- R5: Op 15 produces the 16-bit constant in bits 31..16 with bits 15..0 cleared. No operand value affects the result.
- R6: Legal op 0 instructions report bits 15..11 as the destination index. Legal immediate instructions report bits 20..16.
- R7: When the destination index of a legal instruction is 0, the write enable is 0. The result and destination index are still reported.
- R8: Any op other than 0, 8, 10, 12, 13 and 15, or op 0 with a function other than 0, 2, 32, 34, 36, 37, 39 and 42, sets the illegal flag. In that case the write enable, the result and the destination index are all 0.
- R9: With the output register enabled (the default), the outputs show the instruction sampled at the previous rising clock edge. While reset is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| insn_i | input | 32 | Raw instruction word |
| opa_i | input | 32 | Value of the first source register |
| opb_i | input | 32 | Value of the second source register |
| result_o | output | 32 | Computed result |
| dst_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Result should be written |
| illegal_o | output | 1 | Instruction not supported |

## Verification
The vectors include operands that carry out of bit 31. This separates modular arithmetic from anything that saturates. Signed compares use negative and positive operands in both orders, so a signed compare is told apart from an unsigned one. The constants used have bit 15 set, which shows sign extension against zero extension per instruction. Shifts use patterns with bits near both ends, so that shift direction and zero fill are both visible. Destination tests use distinct values in the two index fields, and use zero in each. Illegal cases cover an unsupported opcode and an unsupported function code under op 0. Reset and a mid-cycle probe confirm that the output stage holds its value until the clock edge.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  localparam int XLEN    = 32;
  localparam int IMM_W   = 16;
  localparam int RIDX_W  = 5;
  localparam int SHAMT_W = 5;
  localparam int OP_W    = 6;
  localparam int FN_W    = 6;

  localparam logic [OP_W-1:0] OPC_RFMT = 6'd0;
  localparam logic [OP_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OP_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OP_W-1:0] OPC_ANDI = 6'd12;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OP_W-1:0] OPC_LUI  = 6'd15;

  localparam logic [FN_W-1:0] FN_SLL = 6'd0;
  localparam logic [FN_W-1:0] FN_SRL = 6'd2;
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLT, ALU_SLL, ALU_SRL, ALU_LUI
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG, OPB_SEXT, OPB_ZEXT
  } opb_sel_e;

  typedef struct packed {
    alu_op_e  op;
    opb_sel_e opb_sel;
    logic     rd_dst;
    logic     legal;
  } dec_t;
endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
  import int_exec_pkg::*;
(
  input  logic [OP_W-1:0] opc_i,
  input  logic [FN_W-1:0] fn_i,
  output dec_t            dec_o
);
  always_comb begin
    dec_o = '{op: ALU_ADD, opb_sel: OPB_REG, rd_dst: 1'b0, legal: 1'b0};
    unique case (opc_i)
      OPC_RFMT: begin
        dec_o.rd_dst = 1'b1;
        dec_o.legal  = 1'b1;
        unique case (fn_i)
          FN_ADD:  dec_o.op = ALU_ADD;
          FN_SUB:  dec_o.op = ALU_SUB;
          FN_AND:  dec_o.op = ALU_AND;
          FN_OR:   dec_o.op = ALU_OR;
          FN_NOR:  dec_o.op = ALU_NOR;
          FN_SLT:  dec_o.op = ALU_SLT;
          FN_SLL:  dec_o.op = ALU_SLL;
          FN_SRL:  dec_o.op = ALU_SRL;
          default: dec_o.legal = 1'b0;
        endcase
      end
      OPC_ADDI: dec_o = '{op: ALU_ADD, opb_sel: OPB_SEXT, rd_dst: 1'b0, legal: 1'b1};
      OPC_SLTI: dec_o = '{op: ALU_SLT, opb_sel: OPB_SEXT, rd_dst: 1'b0, legal: 1'b1};
      OPC_ANDI: dec_o = '{op: ALU_AND, opb_sel: OPB_ZEXT, rd_dst: 1'b0, legal: 1'b1};
      OPC_ORI:  dec_o = '{op: ALU_OR,  opb_sel: OPB_ZEXT, rd_dst: 1'b0, legal: 1'b1};
      OPC_LUI:  dec_o = '{op: ALU_LUI, opb_sel: OPB_ZEXT, rd_dst: 1'b0, legal: 1'b1};
      default:  dec_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_exec_opb.sv
module int_exec_opb
  import int_exec_pkg::*;
#(
  parameter int W = XLEN
) (
  input  opb_sel_e         sel_i,
  input  logic [W-1:0]     reg_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [W-1:0]     opb_o
);
  localparam int EXT_W = W - IMM_W;

  always_comb begin
    unique case (sel_i)
      OPB_SEXT: opb_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      OPB_ZEXT: opb_o = {{EXT_W{1'b0}}, imm_i};
      default:  opb_o = reg_i;
    endcase
  end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import int_exec_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e            op_i,
  input  logic [W-1:0]       a_i,
  input  logic [W-1:0]       b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [W-1:0]       res_o
);
  localparam int LO_W = W - IMM_W;

  logic lt_s;
  assign lt_s = $signed(a_i) < $signed(b_i);

  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_NOR: res_o = ~(a_i | b_i);
      ALU_SLT: res_o = {{(W-1){1'b0}}, lt_s};
      ALU_SLL: res_o = b_i << shamt_i;
      ALU_SRL: res_o = b_i >> shamt_i;
      ALU_LUI: res_o = {b_i[IMM_W-1:0], {LO_W{1'b0}}};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   insn_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  output logic [XLEN-1:0]   result_o,
  output logic [RIDX_W-1:0] dst_o,
  output logic              wr_en_o,
  output logic              illegal_o
);
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;
  localparam int SH_LSB = 6;

  dec_t              dec;
  logic [XLEN-1:0]   opb_eff;
  logic [XLEN-1:0]   alu_res;
  logic [RIDX_W-1:0] rt_idx, rd_idx;
  logic [XLEN-1:0]   res_c;
  logic [RIDX_W-1:0] dst_c;
  logic              wen_c, ill_c;

  assign rt_idx = insn_i[RT_LSB +: RIDX_W];
  assign rd_idx = insn_i[RD_LSB +: RIDX_W];

  int_exec_decode u_dec (
    .opc_i (insn_i[XLEN-1 -: OP_W]),
    .fn_i  (insn_i[FN_W-1:0]),
    .dec_o (dec)
  );

  int_exec_opb #(.W(XLEN)) u_opb (
    .sel_i (dec.opb_sel),
    .reg_i (opb_i),
    .imm_i (insn_i[IMM_W-1:0]),
    .opb_o (opb_eff)
  );

  int_exec_alu #(.W(XLEN)) u_alu (
    .op_i    (dec.op),
    .a_i     (opa_i),
    .b_i     (opb_eff),
    .shamt_i (insn_i[SH_LSB +: SHAMT_W]),
    .res_o   (alu_res)
  );

  always_comb begin
    ill_c = ~dec.legal;
    dst_c = dec.legal ? (dec.rd_dst ? rd_idx : rt_idx) : '0;
    res_c = dec.legal ? alu_res : '0;
    wen_c = dec.legal && (dst_c != '0);
  end

  generate
    if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          result_o  <= '0;
          dst_o     <= '0;
          wr_en_o   <= 1'b0;
          illegal_o <= 1'b0;
        end else begin
          result_o  <= res_c;
          dst_o     <= dst_c;
          wr_en_o   <= wen_c;
          illegal_o <= ill_c;
        end
      end

      p_stage_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (result_o == $past(res_c)) && (wr_en_o == $past(wen_c)))
        else $error("output stage out of step");
    end else begin : g_comb
      assign result_o  = res_c;
      assign dst_o     = dst_c;
      assign wr_en_o   = wen_c;
      assign illegal_o = ill_c;
    end
  endgenerate

  p_illegal_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && result_o == '0 && dst_o == '0))
    else $error("illegal instruction leaked a write");

  p_zero_dst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (dst_o != '0))
    else $error("write enabled to index 0");

  p_slt_bool_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.op == ALU_SLT) |-> (alu_res[XLEN-1:1] == '0))
    else $error("compare result not 0/1");

  p_lui_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.legal && dec.op == ALU_LUI) |-> (alu_res[IMM_W-1:0] == '0))
    else $error("upper-immediate low half not cleared");

  p_rfmt_dst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.legal && insn_i[XLEN-1 -: OP_W] == OPC_RFMT) |-> (dst_c == rd_idx))
    else $error("register-format destination wrong");
endmodule

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;
  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [4:0]  dst;
    logic        wen;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{32'h00221820, 32'h00000005, 32'h00000007, 32'h0000000C, 5'd3,  1'b1, 1'b0, 4'd1}, // R1 add
    '{32'h00221820, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 5'd3,  1'b1, 1'b0, 4'd1}, // R1 wrap
    '{32'h00224022, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 5'd8,  1'b1, 1'b0, 4'd1}, // R1 sub
    '{32'h00221824, 32'h0000F0F0, 32'h0000FF00, 32'h0000F000, 5'd3,  1'b1, 1'b0, 4'd2}, // R2 and
    '{32'h00221825, 32'h0000F0F0, 32'h0000FF00, 32'h0000FFF0, 5'd3,  1'b1, 1'b0, 4'd2}, // R2 or
    '{32'h00221827, 32'h0000000D, 32'h80000009, 32'h7FFFFFF2, 5'd3,  1'b1, 1'b0, 4'd2}, // R2 nor
    '{32'h0022182A, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 5'd3,  1'b1, 1'b0, 4'd3}, // R3 -1<1
    '{32'h0022182A, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 5'd3,  1'b1, 1'b0, 4'd3}, // R3 1<-1
    '{32'h00095100, 32'h0000DEAD, 32'h0100000F, 32'h100000F0, 5'd10, 1'b1, 1'b0, 4'd4}, // R4 sll 4
    '{32'h00095082, 32'h0000DEAD, 32'h8000003C, 32'h2000000F, 5'd10, 1'b1, 1'b0, 4'd4}, // R4 srl 2
    '{32'h2024FFFC, 32'h0000000A, 32'h12345678, 32'h00000006, 5'd4,  1'b1, 1'b0, 4'd1}, // R1 addi -4
    '{32'h20247FFF, 32'h00000000, 32'h12345678, 32'h00007FFF, 5'd4,  1'b1, 1'b0, 4'd1}, // R1 addi max
    '{32'h3025F0F0, 32'hFFFFFFFF, 32'h00000000, 32'h0000F0F0, 5'd5,  1'b1, 1'b0, 4'd2}, // R2 andi zext
    '{32'h34268001, 32'h12340000, 32'hFFFFFFFF, 32'h12348001, 5'd6,  1'b1, 1'b0, 4'd2}, // R2 ori zext
    '{32'h2827FFFF, 32'hFFFFFFFE, 32'h00000000, 32'h00000001, 5'd7,  1'b1, 1'b0, 4'd3}, // R3 slti -2<-1
    '{32'h28270005, 32'h00000005, 32'h00000000, 32'h00000000, 5'd7,  1'b1, 1'b0, 4'd3}, // R3 slti equal
    '{32'h3C09ABCD, 32'hFFFFFFFF, 32'h00001234, 32'hABCD0000, 5'd9,  1'b1, 1'b0, 4'd5}, // R5 lui
    '{32'h00220020, 32'h00000005, 32'h00000007, 32'h0000000C, 5'd0,  1'b0, 1'b0, 4'd7}, // R7 rd=0
    '{32'h20200001, 32'h00000004, 32'h00000000, 32'h00000005, 5'd0,  1'b0, 1'b0, 4'd7}, // R7 rt=0
    '{32'h00000000, 32'h00000009, 32'h00000005, 32'h00000005, 5'd0,  1'b0, 1'b0, 4'd7}, // R7 all-zero word
    '{32'h8C230004, 32'h00000005, 32'h00000007, 32'h00000000, 5'd0,  1'b0, 1'b1, 4'd8}, // R8 op 35
    '{32'h01200008, 32'h00000005, 32'h00000007, 32'h00000000, 5'd0,  1'b0, 1'b1, 4'd8}, // R8 funct 8
    '{32'h10220003, 32'h00000005, 32'h00000007, 32'h00000000, 5'd0,  1'b0, 1'b1, 4'd8}  // R8 op 4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0, opa = '0, opb = '0;
  logic [31:0] result;
  logic [4:0]  dst;
  logic        wr_en, illegal;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .clk_i(clk), .rst_ni(rst_n), .insn_i(insn), .opa_i(opa), .opb_i(opb),
    .result_o(result), .dst_o(dst), .wr_en_o(wr_en), .illegal_o(illegal)
  );

  task automatic check(input string tag, input logic [31:0] r, input logic [4:0] d,
                       input logic w, input logic i);
    n_chk++;
    if (result !== r || dst !== d || wr_en !== w || illegal !== i) begin
      n_fail++;
      $display("FAIL %s: got res=%h dst=%0d wen=%b ill=%b, expected res=%h dst=%0d wen=%b ill=%b",
               tag, result, dst, wr_en, illegal, r, d, w, i);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got no end, expected end of run");
    finish_run();
  end

  initial begin
    // R9 reset state
    insn = 32'h00221820; opa = 32'h1; opb = 32'h2;
    repeat (3) @(negedge clk);
    check("R9 in reset", 32'h0, 5'd0, 1'b0, 1'b0);
    rst_n = 1'b1;

    foreach (VECS[k]) begin
      @(negedge clk);
      insn = VECS[k].insn; opa = VECS[k].a; opb = VECS[k].b;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[k].req, k), VECS[k].res, VECS[k].dst,
            VECS[k].wen, VECS[k].ill);
    end

    // R6 destination choice with distinct rt/rd fields (rt=17, rd=20)
    @(negedge clk);
    insn = 32'h0231A020; opa = 32'h3; opb = 32'h4;
    @(negedge clk);
    check("R6 rd chosen", 32'h7, 5'd20, 1'b1, 1'b0);
    insn = 32'h2231A000; opa = 32'h3;
    @(negedge clk);
    check("R6 rt chosen", 32'hFFFFA003, 5'd17, 1'b1, 1'b0);

    // R4 operand_a unused by shift
    insn = 32'h00095100; opa = 32'hFFFFFFFF; opb = 32'h1;
    @(negedge clk);
    check("R4 opa ignored", 32'h10, 5'd10, 1'b1, 1'b0);

    // R9 output holds until the clock edge
    insn = 32'h00221820; opa = 32'h10; opb = 32'h20;
    #1;
    check("R9 holds before edge", 32'h10, 5'd10, 1'b1, 1'b0);
    @(negedge clk);
    check("R9 updates after edge", 32'h30, 5'd3, 1'b1, 1'b0);

    // R9 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #0.5;
    check("R9 async clear", 32'h0, 5'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", 32'h30, 5'd3, 1'b1, 1'b0);

    finish_run();
  end
endmodule